// File: doc/BRIEF.md
# Sector Instruction Cache Controller

This block manages a small instruction cache. The cache is split into a few sectors. Each sector holds one tag (the upper address bits that it covers) and a run of consecutive instruction words, and every word has its own valid bit. A fetch is looked up in two steps. The first step finds the sector whose tag matches. The second step checks that the addressed word inside that sector is valid. A full hit answers one cycle after the request. On a miss the block raises an external request and waits for fill data. When the fill arrives it writes the word into the array and forwards the word to the requester.

When no sector matches, the block claims one for the new tag. The claimed sector is the least recently used one among those that are not locked. Software can pin a sector by sending a lock command with a sector address, and can release it again with an unlock command.

While the enable input is low, the array is plain program RAM. Reads and writes use the low address bits directly, and all sector state is dropped.

Top module: `sector_icache`

## Requirements
- R1: After reset, `ready` is 1, `respValid` is 0 and `missReq` is 0, and no sector holds a tag.
- R2: A cached fetch whose tag matches no sector gives `missReq`=1 with `missAddr` equal to the fetch address in the next cycle. `ready` stays 0 until the fill. No two sectors ever hold the same tag.
- R3: While a miss is pending, `fillValid` makes `respValid`=1, `respHit`=0 and `respData`=`fillData` in the next cycle, and `ready` returns to 1. If a sector was claimed for the miss, the word becomes valid.
- R4: A fetch of a valid word in a matching sector gives `respValid`=1, `respHit`=1 and the stored word in the next cycle, with no `missReq`.
- R5: Claiming a sector clears all its word valid bits. A fetch that matches the sector but addresses an unfilled word is a miss that fills into that same sector and evicts nothing.
- R6: The sector to claim is the least recently used sector that is not locked. A fetch that matches a sector counts as a use, and so does a claim.
- R7: A lock command on a sector address that is present pins that sector. A lock on a sector address that is absent claims a sector for it and pins it, with no memory request. A pinned sector is never replaced.
- R8: An unlock command returns the matching sector to the replacement pool. An unlock whose sector address is absent changes nothing.
- R9: When every sector is pinned, a fetch that matches no sector is still served through the miss and fill exchange, but nothing is cached: the same fetch misses again.
- R10: A command that arrives in the same cycle as a fetch request, or while a miss is pending, is dropped.
- R11: With `cacheEn`=0, `ramWe`=1 writes `fillData` at array index `fetchAddr[4:0]` (index = sector*8 + word). `fetchReq` returns that word with `respValid`=1 and `respHit`=1 in the next cycle and never raises `missReq`.
- R12: Clearing `cacheEn` drops every sector tag and every lock, and commands issued while it is clear have no effect. After the cache is enabled again, every fetch misses until it is refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cacheEn | input | 1 | 1 = cache operation, 0 = array used as program RAM |
| fetchReq | input | 1 | Fetch request, taken when `ready` is 1 |
| fetchAddr | input | 16 | Fetch address; also the RAM index in disabled mode |
| ready | output | 1 | 1 when no miss is pending |
| respValid | output | 1 | One-cycle pulse with returned instruction word |
| respHit | output | 1 | 1 when the word came from the array |
| respData | output | 24 | Returned instruction word |
| missReq | output | 1 | External fetch request, high while a miss is pending |
| missAddr | output | 16 | Address of the pending miss |
| fillValid | input | 1 | External word available on `fillData` |
| fillData | input | 24 | Fill word; also the write data in RAM mode |
| ramWe | input | 1 | RAM-mode write strobe |
| cmdReq | input | 1 | Lock or unlock command strobe |
| cmdLock | input | 1 | 1 = lock, 0 = unlock |
| cmdSectorAddr | input | 13 | Sector address of the command (fetch address without its word bits) |

## Verification
Two functions can meet in one clock: a fetch request and a lock command. They compete for the single lookup-and-claim path. The bench drives both in the same cycle, sometimes with a lock tag that is absent and would need a claim of its own. It then judges the result by whether that tag survives later evictions, which a bench reference model predicts. Random fetch, lock, unlock and enable-toggle traffic from a fixed seed is mixed with directed runs for the all-pinned case and for unlock of an absent tag.

// File: rtl/sc_pkg.sv
package sc_pkg;
  // strobes from the tag controller to the word array
  typedef struct packed {
    logic rdEn;      // register array word at lookup index into response
    logic wrEn;      // write wrData at write index
    logic setValid;  // mark the written word valid
    logic fwdFill;   // register fill word into response
    logic clrSector; // clear all word valid bits of one sector
    logic clrAll;    // clear every word valid bit
  } arrayStrobes_t;
endpackage

// File: rtl/sc_data_array.sv
module sc_data_array
  import sc_pkg::*;
#(
  parameter int NUM_SEC = 4,
  parameter int WORDS   = 8,
  parameter int DATA_W  = 24
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  arrayStrobes_t                            strb,
  input  logic [$clog2(NUM_SEC)+$clog2(WORDS)-1:0] idx,
  input  logic [$clog2(NUM_SEC)+$clog2(WORDS)-1:0] wrIdx,
  input  logic [DATA_W-1:0]                        wrData,
  input  logic [$clog2(NUM_SEC)-1:0]               clrSec,
  output logic                                     lkValid,
  output logic [DATA_W-1:0]                        rdData
);
  localparam int DEPTH = NUM_SEC * WORDS;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  wordValid;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordValid <= '0;
      rdData    <= '0;
    end else begin
      if (strb.clrAll) begin
        wordValid <= '0;
      end else begin
        if (strb.clrSector) wordValid[clrSec*WORDS +: WORDS] <= '0;
        if (strb.wrEn && strb.setValid) wordValid[wrIdx] <= 1'b1;
      end
      if (strb.fwdFill)   rdData <= wrData;
      else if (strb.rdEn) rdData <= mem[idx];
    end
  end

  assign lkValid = wordValid[idx];

  assert_fill_sets_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrEn && strb.setValid && !strb.clrAll) |=> wordValid[$past(wrIdx)]);

  assert_disable_drops_words_R12: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrAll |=> (wordValid == '0));
endmodule

// File: rtl/sc_tag_ctrl.sv
module sc_tag_ctrl
  import sc_pkg::*;
#(
  parameter int NUM_SEC = 4,
  parameter int WORDS   = 8,
  parameter int ADDR_W  = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cacheEn,
  input  logic                                     fetchReq,
  input  logic [ADDR_W-1:0]                        fetchAddr,
  input  logic                                     cmdReq,
  input  logic                                     cmdLock,
  input  logic [ADDR_W-$clog2(WORDS)-1:0]          cmdSectorAddr,
  input  logic                                     ramWe,
  input  logic                                     fillValid,
  input  logic                                     lkValid,
  output arrayStrobes_t                            strb,
  output logic [$clog2(NUM_SEC)+$clog2(WORDS)-1:0] idx,
  output logic [$clog2(NUM_SEC)+$clog2(WORDS)-1:0] wrIdx,
  output logic [$clog2(NUM_SEC)-1:0]               clrSec,
  output logic                                     ready,
  output logic                                     respValid,
  output logic                                     respHit,
  output logic                                     missReq,
  output logic [ADDR_W-1:0]                        missAddr
);
  localparam int SEC_W = $clog2(NUM_SEC);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = SEC_W + OFF_W;
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0]   tagReg [NUM_SEC];
  logic [SEC_W-1:0]   age    [NUM_SEC];
  logic [NUM_SEC-1:0] sectValid, sectLocked;
  logic               waiting, fillAlloc;
  logic [SEC_W-1:0]   fillSec;

  logic [TAG_W-1:0]   fTag;
  logic [OFF_W-1:0]   fOff;
  logic [NUM_SEC-1:0] matchF, matchC;
  logic               fHitAny, cHitAny, anyFree;
  logic [SEC_W-1:0]   fHitSec, cHitSec, victim;

  logic               touchEn, allocEn, lockSet, lockClr, goWait, respNow;
  logic               nFillAlloc;
  logic [SEC_W-1:0]   touchSec, lockSec, nFillSec;
  logic [TAG_W-1:0]   allocTag;

  assign fTag = fetchAddr[ADDR_W-1:OFF_W];
  assign fOff = fetchAddr[OFF_W-1:0];

  for (genvar i = 0; i < NUM_SEC; i++) begin : g_match
    assign matchF[i] = sectValid[i] && (tagReg[i] == fTag);
    assign matchC[i] = sectValid[i] && (tagReg[i] == cmdSectorAddr);
  end

  assign fHitAny = |matchF;
  assign cHitAny = |matchC;
  assign anyFree = ~&sectLocked;

  // encoders and LRU victim search over unlocked sectors
  always_comb begin
    logic found;
    fHitSec = '0;
    cHitSec = '0;
    victim  = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_SEC; i++) begin
      if (matchF[i]) fHitSec = SEC_W'(i);
      if (matchC[i]) cHitSec = SEC_W'(i);
      if (!sectLocked[i] && (!found || age[i] > age[victim])) begin
        victim = SEC_W'(i);
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    strb       = '0;
    touchEn    = 1'b0;
    touchSec   = victim;
    allocEn    = 1'b0;
    allocTag   = fetchReq ? fTag : cmdSectorAddr;
    lockSet    = 1'b0;
    lockClr    = 1'b0;
    lockSec    = victim;
    goWait     = 1'b0;
    respNow    = 1'b0;
    nFillAlloc = 1'b0;
    nFillSec   = victim;
    clrSec     = victim;
    idx        = cacheEn ? {fHitSec, fOff} : fetchAddr[IDX_W-1:0];
    wrIdx      = cacheEn ? {fillSec, missAddr[OFF_W-1:0]} : fetchAddr[IDX_W-1:0];
    strb.clrAll = !cacheEn;
    if (waiting) begin
      if (fillValid) begin
        strb.fwdFill  = 1'b1;
        strb.wrEn     = fillAlloc && cacheEn;
        strb.setValid = fillAlloc && cacheEn;
      end
    end else if (!cacheEn) begin
      strb.rdEn = fetchReq;
      strb.wrEn = ramWe;
      respNow   = fetchReq;
    end else if (fetchReq) begin
      goWait = 1'b1;
      if (fHitAny) begin
        touchEn    = 1'b1;
        touchSec   = fHitSec;
        nFillAlloc = 1'b1;
        nFillSec   = fHitSec;
        if (lkValid) begin
          strb.rdEn = 1'b1;
          respNow   = 1'b1;
          goWait    = 1'b0;
        end
      end else if (anyFree) begin
        allocEn        = 1'b1;
        strb.clrSector = 1'b1;
        touchEn        = 1'b1;
        nFillAlloc     = 1'b1;
      end
    end else if (cmdReq) begin
      if (cHitAny) begin
        lockSec = cHitSec;
        lockSet = cmdLock;
        lockClr = !cmdLock;
      end else if (cmdLock && anyFree) begin
        allocEn        = 1'b1;
        strb.clrSector = 1'b1;
        touchEn        = 1'b1;
        lockSet        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sectValid  <= '0;
      sectLocked <= '0;
      waiting    <= 1'b0;
      fillAlloc  <= 1'b0;
      fillSec    <= '0;
      missReq    <= 1'b0;
      missAddr   <= '0;
      respValid  <= 1'b0;
      respHit    <= 1'b0;
      for (int i = 0; i < NUM_SEC; i++) begin
        tagReg[i] <= '0;
        age[i]    <= SEC_W'(i);
      end
    end else begin
      respValid <= respNow || (waiting && fillValid);
      respHit   <= respNow;
      if (waiting && fillValid) begin
        waiting <= 1'b0;
        missReq <= 1'b0;
      end else if (goWait) begin
        waiting   <= 1'b1;
        missReq   <= 1'b1;
        missAddr  <= fetchAddr;
        fillAlloc <= nFillAlloc;
        fillSec   <= nFillSec;
      end
      if (!cacheEn) begin
        sectValid  <= '0;
        sectLocked <= '0;
      end else begin
        if (allocEn) begin
          tagReg[victim]     <= allocTag;
          sectValid[victim]  <= 1'b1;
          sectLocked[victim] <= 1'b0;
        end
        if (lockSet) sectLocked[lockSec] <= 1'b1;
        if (lockClr) sectLocked[lockSec] <= 1'b0;
      end
      if (touchEn) begin
        for (int j = 0; j < NUM_SEC; j++) begin
          if (j == int'(touchSec))         age[j] <= '0;
          else if (age[j] < age[touchSec]) age[j] <= age[j] + 1'b1;
        end
      end
    end
  end

  assign ready = !waiting;

  assert_unique_tags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(matchF));

  assert_miss_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    missReq |-> !ready);

  assert_fill_response_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && fillValid) |=> (respValid && !respHit && ready));

  assert_hit_no_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cacheEn && fetchReq && fHitAny && lkValid) |=> (respValid && respHit && !missReq));

  assert_disable_drops_tags_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cacheEn |=> (sectValid == '0 && sectLocked == '0));

  for (genvar i = 0; i < NUM_SEC; i++) begin : g_pin
    assert_pinned_tag_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sectLocked[i] && cacheEn) |=> ($stable(tagReg[i]) && sectValid[i]));
  end
endmodule

// File: rtl/sector_icache.sv
module sector_icache
  import sc_pkg::*;
#(
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_WORDS = 8,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 24
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cacheEn,
  input  logic                                     fetchReq,
  input  logic [ADDR_W-1:0]                        fetchAddr,
  output logic                                     ready,
  output logic                                     respValid,
  output logic                                     respHit,
  output logic [DATA_W-1:0]                        respData,
  output logic                                     missReq,
  output logic [ADDR_W-1:0]                        missAddr,
  input  logic                                     fillValid,
  input  logic [DATA_W-1:0]                        fillData,
  input  logic                                     ramWe,
  input  logic                                     cmdReq,
  input  logic                                     cmdLock,
  input  logic [ADDR_W-$clog2(SECTOR_WORDS)-1:0]   cmdSectorAddr
);
  localparam int SEC_W = $clog2(NUM_SECTORS);
  localparam int IDX_W = SEC_W + $clog2(SECTOR_WORDS);

  arrayStrobes_t    strb;
  logic [IDX_W-1:0] idx, wrIdx;
  logic [SEC_W-1:0] clrSec;
  logic             lkValid;

  sc_tag_ctrl #(.NUM_SEC(NUM_SECTORS), .WORDS(SECTOR_WORDS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rst_n, .cacheEn, .fetchReq, .fetchAddr, .cmdReq, .cmdLock, .cmdSectorAddr,
    .ramWe, .fillValid, .lkValid, .strb, .idx, .wrIdx, .clrSec,
    .ready, .respValid, .respHit, .missReq, .missAddr
  );

  sc_data_array #(.NUM_SEC(NUM_SECTORS), .WORDS(SECTOR_WORDS), .DATA_W(DATA_W)) u_array (
    .clk, .rst_n, .strb, .idx, .wrIdx, .wrData(fillData), .clrSec,
    .lkValid, .rdData(respData)
  );
endmodule

// File: tb/sector_icache_tb.sv
module sector_icache_tb;
  localparam int NS = 4;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cacheEn = 1'b1;
  logic        fetchReq = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic        ready, respValid, respHit, missReq;
  logic [23:0] respData;
  logic [15:0] missAddr;
  logic        fillValid = 1'b0;
  logic [23:0] fillData = '0;
  logic        ramWe = 1'b0;
  logic        cmdReq = 1'b0;
  logic        cmdLock = 1'b0;
  logic [12:0] cmdSectorAddr = '0;

  always #2 clk = ~clk;

  sector_icache u_dut (
    .clk, .rst_n, .cacheEn, .fetchReq, .fetchAddr, .ready, .respValid, .respHit,
    .respData, .missReq, .missAddr, .fillValid, .fillData, .ramWe,
    .cmdReq, .cmdLock, .cmdSectorAddr
  );

  int errors = 0;
  int checks = 0;
  int stampNow = 0;
  int fillCnt = 0;

  // reference model
  logic [12:0] mTag [NS];
  bit          mVal [NS];
  bit          mLock[NS];
  int          mStamp[NS];
  bit          mWv  [NS][NW];
  logic [23:0] mData[NS][NW];
  logic [23:0] ramM [32];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int findSlot(input logic [12:0] t);
    for (int i = 0; i < NS; i++) if (mVal[i] && mTag[i] == t) return i;
    return -1;
  endfunction

  function automatic int pickVictim();
    int v = -1;
    for (int i = 0; i < NS; i++)
      if (!mLock[i] && (v < 0 || mStamp[i] < mStamp[v])) v = i;
    return v;
  endfunction

  function automatic void touch(input int s);
    stampNow++;
    mStamp[s] = stampNow;
  endfunction

  function automatic void claim(input int s, input logic [12:0] t);
    mTag[s] = t; mVal[s] = 1; mLock[s] = 0;
    for (int w = 0; w < NW; w++) mWv[s][w] = 0;
    touch(s);
  endfunction

  function automatic void dropAll();
    for (int i = 0; i < NS; i++) begin mVal[i] = 0; mLock[i] = 0; mStamp[i] = 0; end
  endfunction

  // fetch, optionally with a colliding command in the same cycle (R10)
  task automatic doFetch(input logic [15:0] a, input bit withCmd, input logic [12:0] ct);
    int s = findSlot(a[15:3]);
    int off = int'(a[2:0]);
    bit expHit = (s >= 0) && mWv[s][off];
    @(negedge clk);
    fetchReq = 1; fetchAddr = a;
    if (withCmd) begin cmdReq = 1; cmdLock = 1; cmdSectorAddr = ct; end
    @(posedge clk);
    @(negedge clk);
    fetchReq = 0; cmdReq = 0;
    if (expHit) begin
      check(respValid && respHit, "R4 hit response", {respValid, respHit}, 2'b11);
      check(respData == mData[s][off], "R4 hit data", respData, mData[s][off]);
      check(!missReq, "R4 no miss on hit", missReq, 0);
      touch(s);
    end else begin
      check(missReq && missAddr == a, "R2 miss request", {missReq, missAddr}, {1'b1, a});
      check(!ready && !respValid, "R2 busy during miss", {ready, respValid}, 0);
      if (s >= 0) touch(s);
      else begin
        s = pickVictim();
        if (s >= 0) claim(s, a[15:3]);
      end
      repeat ($urandom_range(0, 3)) @(negedge clk);
      fillCnt++;
      fillValid = 1; fillData = {a, fillCnt[7:0]};
      @(posedge clk);
      @(negedge clk);
      fillValid = 0;
      check(respValid && !respHit && ready, "R3 fill response", {respValid, respHit, ready}, 3'b101);
      check(respData == {a, fillCnt[7:0]}, "R3 fill data", respData, {a, fillCnt[7:0]});
      check(!missReq, "R3 miss cleared", missReq, 0);
      if (s >= 0) begin mWv[s][off] = 1; mData[s][off] = {a, fillCnt[7:0]}; end
    end
  endtask

  task automatic doCmd(input bit lock, input logic [12:0] t);
    int s = findSlot(t);
    @(negedge clk);
    cmdReq = 1; cmdLock = lock; cmdSectorAddr = t;
    @(posedge clk);
    @(negedge clk);
    cmdReq = 0;
    check(!missReq && !respValid && ready, "R7 command makes no request", {missReq, respValid, ready}, 3'b001);
    if (!cacheEn) return;
    if (s >= 0) mLock[s] = lock;
    else if (lock) begin
      s = pickVictim();
      if (s >= 0) begin claim(s, t); mLock[s] = 1; end
    end
  endtask

  task automatic setEnable(input bit en);
    @(negedge clk);
    cacheEn = en;
    @(posedge clk);
    @(negedge clk);
    if (!en) dropAll();
  endtask

  task automatic ramWrite(input logic [4:0] i, input logic [23:0] d);
    @(negedge clk);
    ramWe = 1; fetchAddr = {11'd0, i}; fillData = d;
    @(posedge clk);
    @(negedge clk);
    ramWe = 0;
    ramM[i] = d;
  endtask

  task automatic ramRead(input logic [4:0] i);
    @(negedge clk);
    fetchReq = 1; fetchAddr = {11'd0, i};
    @(posedge clk);
    @(negedge clk);
    fetchReq = 0;
    check(respValid && respHit && !missReq, "R11 RAM read response", {respValid, respHit, missReq}, 3'b110);
    check(respData == ramM[i], "R11 RAM read data", respData, ramM[i]);
  endtask

  function automatic logic [15:0] mkAddr(input int t, input int w);
    return 16'((t << 3) | w);
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    dropAll();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(ready && !respValid && !missReq, "R1 reset outputs", {ready, respValid, missReq}, 3'b100);
    doFetch(mkAddr(1, 0), 0, 0);   // R1 first fetch misses
    doFetch(mkAddr(1, 0), 0, 0);   // R4 hit
    doFetch(mkAddr(1, 5), 0, 0);   // R5 word miss in same sector
    doFetch(mkAddr(1, 5), 0, 0);
    doFetch(mkAddr(2, 1), 0, 0);
    doFetch(mkAddr(3, 1), 0, 0);
    doFetch(mkAddr(4, 1), 0, 0);
    doFetch(mkAddr(1, 0), 0, 0);   // R6 tag 1 recently used
    doFetch(mkAddr(5, 2), 0, 0);   // evicts tag 2 (R6)
    doFetch(mkAddr(2, 1), 0, 0);
    doFetch(mkAddr(1, 5), 0, 0);
    // R7 / R9 pin every sector
    doCmd(1, 13'd10); doCmd(1, 13'd11); doCmd(1, 13'd12); doCmd(1, 13'd13);
    doFetch(mkAddr(20, 0), 0, 0);  // R9 not cached
    doFetch(mkAddr(20, 0), 0, 0);  // R9 misses again
    doFetch(mkAddr(10, 3), 0, 0);
    doFetch(mkAddr(10, 3), 0, 0);
    doCmd(0, 13'd30);              // R8 absent unlock, no effect
    doFetch(mkAddr(21, 0), 0, 0);
    doCmd(0, 13'd11);              // R8 release
    doFetch(mkAddr(20, 0), 0, 0);
    doFetch(mkAddr(20, 0), 0, 0);
    doFetch(mkAddr(11, 0), 0, 0);
    doCmd(0, 13'd10); doCmd(0, 13'd12); doCmd(0, 13'd13);
    // R10 collision: fetch wins, lock dropped
    doFetch(mkAddr(6, 4), 1, 13'd7);
    doFetch(mkAddr(7, 0), 0, 0);
    doFetch(mkAddr(6, 4), 1, 13'd7);
    for (int k = 0; k < 5; k++) doFetch(mkAddr(22 + k, 0), 0, 0);
    doFetch(mkAddr(7, 0), 0, 0);
    // R11 / R12 RAM mode
    doCmd(1, 13'd22);
    setEnable(0);
    for (int k = 0; k < 32; k++) ramWrite(5'(k), 24'h5A0000 ^ 24'(k * 37));
    ramRead(5'd0); ramRead(5'd31); ramRead(5'd9);
    doCmd(1, 13'd3);               // R12 ignored
    setEnable(1);
    doFetch(mkAddr(26, 0), 0, 0);  // R12 all dropped
    doFetch(mkAddr(22, 0), 0, 0);
    // random traffic
    for (int n = 0; n < 500; n++) begin
      int r = $urandom_range(0, 99);
      int t = $urandom_range(0, 6);
      if (r < 70)      doFetch(mkAddr(t, $urandom_range(0, 3)), 0, 0);
      else if (r < 80) doCmd(1, 13'(t));
      else if (r < 90) doCmd(0, 13'(t));
      else if (r < 96) doFetch(mkAddr(t, $urandom_range(0, 3)), 1, 13'($urandom_range(0, 6)));
      else begin
        setEnable(0);
        ramWrite(5'($urandom_range(0, 31)), 24'($urandom));
        for (int k = 0; k < 32; k++) if (k % 8 == 0) ramWrite(5'(k), 24'(k + n));
        ramRead(5'(8 * $urandom_range(0, 3)));
        setEnable(1);
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R3 actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule